// File: doc/BRIEF.md
# Program Counter and Fetch Stage

This block owns the fetch address of a small 32-bit RISC pipeline whose instructions are all one word wide. Every cycle it picks the address to fetch next: the following word, the target of a conditional branch that compares two register values for equality, or the target of an absolute jump. Branches and jumps are resolved from the instruction sitting in the fetch/decode register, with the two compare operands supplied by the register-file read ports of the surrounding chip.

The instruction memory is synchronous. The block presents the next fetch address before a clock edge, and the matching word returns on the data input during the following cycle. At the next edge that word is captured, together with its address, into the fetch/decode register. The design assumes a branch is not taken. The word behind a branch or jump is fetched anyway and is replaced by a bubble when the redirect happens, so every taken control transfer costs one cycle.

A stall input freezes the program counter and the fetch/decode register so that decode sees the same instruction again. A flush input replaces whatever would land in the fetch/decode register with a bubble. A redirect that arrives during a stall is kept internally and applied on the first cycle without a stall.

Top module: `ifu_fetch`

## Requirements
- R1: A synchronous reset sets the fetch address to 0 and loads the fetch/decode register with a bubble: instruction 0, address 0, valid 0.
- R2: In a cycle with no stall and no redirect, the program counter advances by 4. The fetch/decode register takes the word returned for the old program counter, with that address and valid set to 1.
- R3: A valid decode instruction with opcode 4 in bits 31:26 (branch-if-equal) whose two operand inputs are equal redirects fetch. The target is its own address plus 4 plus the sign-extended bits 15:0 shifted left by 2.
- R4: A branch-if-equal whose operands differ does not redirect, and fetch continues sequentially. An invalid decode entry never redirects.
- R5: A valid decode instruction with opcode 2 in bits 31:26 (jump) always redirects. The target is bits 31:28 of the jump's own address, then instruction bits 25:0, then two zero bits.
- R6: On an unstalled redirect, the fetch/decode register receives a bubble in place of the wrong-path word. Exactly one bubble results.
- R7: While the stall input is high, the program counter and the fetch/decode register keep their values (a flush still clears the register, as in R9).
- R8: A redirect seen while stalled is captured. Later operand changes during the stall do not affect it, and it is applied on the first cycle in which the stall is low.
- R9: A flush loads the fetch/decode register with a bubble in that cycle and does not change the program counter update.
- R10: The memory address output always equals the value the program counter takes at the next clock edge, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze the program counter and the fetch/decode register |
| flush_i | input | 1 | Replace the next fetch/decode contents with a bubble |
| opa_i | input | 32 | First compare operand for the decode-stage branch |
| opb_i | input | 32 | Second compare operand for the decode-stage branch |
| imem_addr_o | output | 32 | Byte address presented to the synchronous instruction memory |
| imem_data_i | input | 32 | Word returned one cycle after its address |
| pc_o | output | 32 | Address of the word now being fetched |
| fd_instr_o | output | 32 | Fetch/decode instruction |
| fd_pc_o | output | 32 | Address of the fetch/decode instruction |
| fd_valid_o | output | 1 | Fetch/decode entry holds a live instruction |

## Verification
The assertions assume that the memory returns, during the cycle after an address, the word for that address. They also assume that the operand inputs are driven to known values whenever a branch sits in decode. The bench's memory model registers its word on the same edge at which the block loads its program counter, and it drives both operands every cycle. Stall, flush and operand equality are drawn freely and in every combination. The operands are re-drawn in each stalled cycle, so a captured redirect faces operands that no longer match it. All branch and jump targets in the memory image stay inside the modelled window.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned INSN_W  = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JFLD_W  = 26;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
    localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } fd_entry_t;

    localparam fd_entry_t FD_BUBBLE = '{insn: '0, addr: '0, valid: 1'b0};
endpackage

// File: rtl/ifu_resolve.sv
module ifu_resolve
    import ifu_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned IW   = INSN_W,
    parameter int unsigned IMW  = IMM_W,
    parameter int unsigned JW   = JFLD_W
) (
    input  logic [IW-1:0] insn_i,
    input  logic [AW-1:0] addr_i,
    input  logic          valid_i,
    input  logic [AW-1:0] opa_i,
    input  logic [AW-1:0] opb_i,
    output logic          redir_o,
    output logic [AW-1:0] tgt_o
);
    localparam int unsigned OP_LO  = IW - OPC_W;
    localparam int unsigned HI_W   = AW - JW - 2;
    localparam int unsigned EXT_W  = AW - IMW - 2;

    logic [OPC_W-1:0] opcode;
    logic [AW-1:0]    seq_addr;
    logic [AW-1:0]    disp;
    logic [AW-1:0]    br_tgt;
    logic [AW-1:0]    jmp_tgt;
    logic             is_beq;
    logic             is_jmp;

    always_comb begin
        opcode   = insn_i[IW-1:OP_LO];
        is_beq   = (opcode == OPC_BEQ);
        is_jmp   = (opcode == OPC_JMP);
        seq_addr = addr_i + AW'(4);
        disp     = {{EXT_W{insn_i[IMW-1]}}, insn_i[IMW-1:0], 2'b00};
        br_tgt   = seq_addr + disp;
        jmp_tgt  = {addr_i[AW-1 -: HI_W], insn_i[JW-1:0], 2'b00};
        redir_o  = valid_i & (is_jmp | (is_beq & (opa_i == opb_i)));
        tgt_o    = is_jmp ? jmp_tgt : br_tgt;
    end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned STEP = 4
) (
    input  logic [AW-1:0] pc_i,
    input  logic          stall_i,
    input  logic          live_v_i,
    input  logic [AW-1:0] live_tgt_i,
    input  logic          held_v_i,
    input  logic [AW-1:0] held_tgt_i,
    output logic [AW-1:0] pc_o,
    output logic          held_v_o,
    output logic [AW-1:0] held_tgt_o,
    output logic          squash_o
);
    logic          want_v;
    logic [AW-1:0] want_tgt;

    always_comb begin
        want_v   = held_v_i | live_v_i;
        want_tgt = held_v_i ? held_tgt_i : live_tgt_i;
        if (stall_i) begin
            pc_o       = pc_i;
            squash_o   = 1'b0;
            held_v_o   = want_v;
            held_tgt_o = want_tgt;
        end else begin
            pc_o       = want_v ? want_tgt : pc_i + AW'(STEP);
            squash_o   = want_v;
            held_v_o   = 1'b0;
            held_tgt_o = '0;
        end
    end
endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
    import ifu_pkg::*;
#(
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned IW       = INSN_W,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall_i,
    input  logic          flush_i,
    input  logic [AW-1:0] opa_i,
    input  logic [AW-1:0] opb_i,
    output logic [AW-1:0] imem_addr_o,
    input  logic [IW-1:0] imem_data_i,
    output logic [AW-1:0] pc_o,
    output logic [IW-1:0] fd_instr_o,
    output logic [AW-1:0] fd_pc_o,
    output logic          fd_valid_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [IW-1:0] fd_insn;
        logic [AW-1:0] fd_addr;
        logic          fd_valid;
        logic          held_v;
        logic [AW-1:0] held_tgt;
    } state_t;

    localparam state_t ST_RESET = '{pc: AW'(RESET_PC), fd_insn: '0, fd_addr: '0,
                                    fd_valid: 1'b0, held_v: 1'b0, held_tgt: '0};

    state_t st_d, st_q;

    logic          live_v;
    logic [AW-1:0] live_tgt;
    logic [AW-1:0] pc_nxt;
    logic          held_v_nxt;
    logic [AW-1:0] held_tgt_nxt;
    logic          squash;

    ifu_resolve #(.AW(AW), .IW(IW)) u_resolve (
        .insn_i  (st_q.fd_insn),
        .addr_i  (st_q.fd_addr),
        .valid_i (st_q.fd_valid),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .redir_o (live_v),
        .tgt_o   (live_tgt)
    );

    ifu_next_pc #(.AW(AW), .STEP(IW/8)) u_next (
        .pc_i       (st_q.pc),
        .stall_i    (stall_i),
        .live_v_i   (live_v),
        .live_tgt_i (live_tgt),
        .held_v_i   (st_q.held_v),
        .held_tgt_i (st_q.held_tgt),
        .pc_o       (pc_nxt),
        .held_v_o   (held_v_nxt),
        .held_tgt_o (held_tgt_nxt),
        .squash_o   (squash)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pc       = pc_nxt;
        st_d.held_v   = held_v_nxt;
        st_d.held_tgt = held_tgt_nxt;
        if (flush_i || (!stall_i && squash)) begin
            st_d.fd_insn  = '0;
            st_d.fd_addr  = '0;
            st_d.fd_valid = 1'b0;
        end else if (!stall_i) begin
            st_d.fd_insn  = imem_data_i;
            st_d.fd_addr  = st_q.pc;
            st_d.fd_valid = 1'b1;
        end
        if (rst) begin
            st_d = ST_RESET;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr_o = st_d.pc;
    assign pc_o        = st_q.pc;
    assign fd_instr_o  = st_q.fd_insn;
    assign fd_pc_o     = st_q.fd_addr;
    assign fd_valid_o  = st_q.fd_valid;

    // R10
    addr_leads_pc_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_o == $past(imem_addr_o)));

    // R7
    stall_holds_pc_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> (pc_o == $past(pc_o)));

    // R7
    stall_holds_fd_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !flush_i) |=> (fd_instr_o == $past(fd_instr_o) &&
                                   fd_valid_o == $past(fd_valid_o)));

    // R9
    flush_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!fd_valid_o && fd_instr_o == '0));

    // R6
    redirect_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (squash && !stall_i) |=> !fd_valid_o);

    // R8
    held_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.held_v && !stall_i) |=> (!st_q.held_v && pc_o == $past(st_q.held_tgt)));
endmodule

// File: tb/sim_ifu_fetch.sv
`timescale 1ns/1ps
module sim_ifu_fetch;
    localparam int unsigned CYC   = 20;
    localparam int unsigned WORDS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] imem_addr_o;
    logic [31:0] imem_data_i;
    logic [31:0] pc_o;
    logic [31:0] fd_instr_o;
    logic [31:0] fd_pc_o;
    logic        fd_valid_o;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [0:WORDS-1];

    always #(CYC/2) clk = ~clk;

    always @(posedge clk) imem_data_i <= mem[imem_addr_o[7:2]];

    ifu_fetch u0 (
        .clk(clk), .rst(rst), .stall_i(stall_i), .flush_i(flush_i),
        .opa_i(opa_i), .opb_i(opb_i), .imem_addr_o(imem_addr_o),
        .imem_data_i(imem_data_i), .pc_o(pc_o), .fd_instr_o(fd_instr_o),
        .fd_pc_o(fd_pc_o), .fd_valid_o(fd_valid_o)
    );

    // bench model state
    logic [31:0] m_pc, m_insn, m_addr, m_ht;
    logic        m_v, m_hv;
    string       pc_tag, fd_tag;
    logic [31:0] n_pc, n_insn, n_addr, n_ht;
    logic        n_v, n_hv;
    string       n_pc_tag, n_fd_tag;
    int          held_seen = 0;

    function automatic logic [31:0] make_word(int i);
        int sel;
        int tgt;
        int off;
        sel = (i * 5 + 3) % 8;
        tgt = (i * 11 + 7) % WORDS;
        if (i != 0 && (sel == 0 || sel == 4)) begin
            off = tgt - (i + 1);
            return {6'd4, 5'd1, 5'd2, off[15:0]};
        end else if (i != 0 && sel == 2) begin
            tgt = (i * 13 + 5) % WORDS;
            return {6'd2, 26'(tgt)};
        end
        return {6'd0, 26'(i * 977 + 1)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_next(bit r, bit s, bit f);
        logic        live;
        logic [31:0] ltgt;
        logic [5:0]  op;
        logic [31:0] imm_ext;
        op = m_insn[31:26];
        imm_ext = {{14{m_insn[15]}}, m_insn[15:0], 2'b00};
        live = m_v && ((op == 6'd4 && opa_i == opb_i) || op == 6'd2);
        ltgt = (op == 6'd2) ? {m_addr[31:28], m_insn[25:0], 2'b00}
                            : m_addr + 32'd4 + imm_ext;
        n_pc = m_pc; n_insn = m_insn; n_addr = m_addr; n_v = m_v;
        n_hv = m_hv; n_ht = m_ht;
        if (r) begin
            n_pc = 0; n_insn = 0; n_addr = 0; n_v = 0; n_hv = 0; n_ht = 0;
            n_pc_tag = "R1"; n_fd_tag = "R1";
            return;
        end
        if (s) begin
            n_pc_tag = "R7";
            n_fd_tag = f ? "R9" : "R7";
            if (!m_hv && live) begin
                n_hv = 1; n_ht = ltgt; held_seen++;
            end
            if (f) begin n_insn = 0; n_addr = 0; n_v = 0; end
            return;
        end
        n_hv = 0; n_ht = 0;
        if (m_hv || live) begin
            n_pc = m_hv ? m_ht : ltgt;
            n_pc_tag = m_hv ? "R8" : ((op == 6'd2) ? "R5" : "R3");
            n_fd_tag = f ? "R9" : "R6";
            n_insn = 0; n_addr = 0; n_v = 0;
        end else begin
            n_pc = m_pc + 32'd4;
            n_pc_tag = (m_v && op == 6'd4) ? "R4" : "R2";
            n_fd_tag = f ? "R9" : "R2";
            if (f) begin
                n_insn = 0; n_addr = 0; n_v = 0;
            end else begin
                n_insn = mem[m_pc[7:2]]; n_addr = m_pc; n_v = 1;
            end
        end
    endtask

    // one cycle: called at a negedge, leaves at the next negedge
    task automatic step(bit r, bit s, bit f, bit eq);
        logic [31:0] a;
        a = $urandom;
        rst = r; stall_i = s; flush_i = f;
        opa_i = a;
        opb_i = eq ? a : (a ^ (32'd1 << ($urandom % 32)));
        #1;
        model_next(r, s, f);
        chk("R10", "imem_addr", imem_addr_o, n_pc);
        @(posedge clk);
        m_pc = n_pc; m_insn = n_insn; m_addr = n_addr; m_v = n_v;
        m_hv = n_hv; m_ht = n_ht; pc_tag = n_pc_tag; fd_tag = n_fd_tag;
        @(negedge clk);
        chk(pc_tag, "pc", pc_o, m_pc);
        chk(fd_tag, "fd_valid", {31'd0, fd_valid_o}, {31'd0, m_v});
        chk(fd_tag, "fd_instr", fd_instr_o, m_insn);
        chk(fd_tag, "fd_pc", fd_pc_o, m_addr);
    endtask

    initial begin
        #(CYC * 150000);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = make_word(i);
        m_pc = 0; m_insn = 0; m_addr = 0; m_v = 0; m_hv = 0; m_ht = 0;
        @(negedge clk);
        // R1: reset state
        step(1, 0, 0, 0);
        step(1, 1, 1, 1);
        // R2/R3/R4/R5/R6: free-running fetch with branch outcomes swept
        for (int c = 0; c < 400; c++) step(0, 0, 0, ($urandom % 2) == 1);
        // R1: reset in mid-run
        step(1, 0, 0, 1);
        // R7/R8/R9: stalls and flushes in every combination
        for (int c = 0; c < 2000; c++)
            step(0, ($urandom % 10) < 4, ($urandom % 10) == 0, ($urandom % 2) == 1);
        // R8: long stalls behind a redirect, operands re-drawn each cycle
        for (int c = 0; c < 300; c++)
            step(0, (c % 6) != 5, 1'b0, ($urandom % 3) != 0);
        // R8: the captured-redirect path must have been exercised
        chk("R8", "held_redirects_seen_nonzero", {31'd0, held_seen > 0}, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule